// File: doc/BRIEF.md
# Converter Result Read Port (I2C Slave)

This block is the serial front end of a data converter that can only be read. It watches the two I2C lines with a fast system clock. Each line passes through a synchronizer and a small glitch filter before edges are detected. The block recognizes START, repeated START and STOP, and compares the first byte after a START against a fixed 7-bit address followed by a direction bit.

When a read request for its address arrives, the block asks the converter core whether a result is ready. If the core is still converting, the request is refused with a NAK. If a result is ready, the block acknowledges the request and returns the 16-bit signed result as two bytes, most significant bit first. The block checks the master's acknowledge after each byte.

Ending a read starts the next conversion. A read ends when both bytes have been sent, when the master NAKs the first byte, or when a START or STOP arrives after the address was acknowledged. In each case the block emits a one-cycle conversion-start pulse. SDA is driven only as open drain, through an output enable that pulls the line low.

Top module: `conv_result_i2c_port`

## Requirements
- R1: A first byte of 0x29 after START (address 0010100 in bits 7..1, bit 0 = 1 meaning read) is acknowledged when conv_done is 1. The block pulls SDA low during the ninth SCL clock.
- R2: A matching read request that arrives while conv_done is 0 gets a NAK: SDA stays released during the ninth clock and on every clock after it. No conversion-start pulse is produced.
- R3: A first byte whose address bits differ from 0010100, or whose bit 0 is 0, gets a NAK. The block then leaves SDA released on all further clocks until the next START or STOP, and produces no conversion-start pulse.
- R4: After an ACK, the block shifts out the result captured at the ACK decision. Bits go out MSB first, bit 15 first, as a high byte and then a low byte. Each bit is placed on SDA after a falling SCL edge, and the SDA enable changes only while the filtered SCL is low.
- R5: If the master ACKs the first byte, the low byte follows. After the low byte's acknowledge clock, the read ends with exactly one conversion-start pulse, one system clock long, whatever the master's acknowledge was.
- R6: If the master NAKs the first byte, the read ends with one conversion-start pulse. SDA stays released on further clocks until the next START or STOP.
- R7: A STOP that follows an acknowledged address, with no data clocked, discards the result and produces one conversion-start pulse.
- R8: A repeated START behaves like a START and begins a new address phase. A repeated START that arrives during an acknowledged read ends that read with one conversion-start pulse.
- R9: A pulse on SCL or SDA shorter than FILT_LEN system clocks has no effect on the transfer.
- R10: While rst_n is low, sda_oe and conv_start are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| conv_start | output | 1 | One-cycle pulse that starts a new conversion |
| conv_done | input | 1 | 1 when the core holds a finished result |
| result | input | 16 | Finished conversion result, bit 15 is the sign |

## Verification
Directed transfers cover the following cases:
- a full two-byte read;
- a re-address while the core is busy;
- a wrong address and a write request;
- a STOP straight after the ACK;
- a master NAK after the high byte;
- a repeated START in the middle of a read and after a refused address;
- an address phase with short spikes on both lines.

Each case is told apart by the ACK bit, the data returned and the number of conversion-start pulses. A seeded random phase mixes addresses, core-busy timing and the ways a read can end. This checks that refusal depends only on the address and the done flag, and that every accepted read yields exactly one new conversion.

// File: rtl/conv_i2c_pkg.sv
// Package: shared types and constants for the converter result read port.
// Assumes: nothing beyond IEEE 1800-2017.
package conv_i2c_pkg;

    // Protocol phases of the read port
    typedef enum logic [2:0] {
        ST_IDLE,  // bus free or finished, waiting for START
        ST_ADDR,  // shifting in address and direction bit
        ST_AACK,  // ninth clock of the address byte
        ST_TX,    // shifting data bits out
        ST_MACK,  // ninth clock of a data byte, master answers
        ST_SKIP   // not addressed or read ended, wait for START/STOP
    } port_state_t;

    localparam logic [6:0] DEF_SLAVE_ADDR = 7'b0010100;

endpackage

// File: rtl/line_filter.sv
// Module: line_filter
// Brings one asynchronous bus line into the clk domain through a
// synchronizer chain, then accepts a new level only after it has been
// seen on FILT_LEN consecutive clocks.
// Assumes: SYNC_STAGES >= 2, FILT_LEN >= 2.
module line_filter #(
    parameter int   SYNC_STAGES = 2,
    parameter int   FILT_LEN    = 4,
    parameter logic RST_VAL     = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_cnt;
    logic                   level_q;

    // Synchronizer chain, shift toward the top bit
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= {SYNC_STAGES{RST_VAL}};
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
    end

    // Glitch filter: count differing samples, switch after FILT_LEN in a row
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            level_q <= RST_VAL;
        end else if (sync_q[SYNC_STAGES-1] == level_q) begin
            run_cnt <= '0;
        end else if (run_cnt == CW'(FILT_LEN - 1)) begin
            run_cnt <= '0;
            level_q <= sync_q[SYNC_STAGES-1];
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign dout = level_q;
endmodule

// File: rtl/bus_events.sv
// Module: bus_events
// Turns filtered SCL/SDA levels into one-cycle events: SCL rise and
// fall, START (SDA falls while SCL high) and STOP (SDA rises while SCL high).
// Assumes: inputs are already synchronous and glitch filtered.
module bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_q, sda_q;

    // Previous-cycle copies of both lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    assign scl_rise  =  scl & ~scl_q;
    assign scl_fall  = ~scl &  scl_q;
    assign start_evt =  scl &  scl_q &  sda_q & ~sda;
    assign stop_evt  =  scl &  scl_q & ~sda_q &  sda;
endmodule

// File: rtl/conv_result_i2c_port.sv
// Module: conv_result_i2c_port
// Read-only I2C slave for a converter result. Matches a fixed address
// with the read bit, ACKs only when the core reports a finished result,
// sends DATA_W bits MSB first in bytes, and pulses conv_start whenever an
// acknowledged read ends (all bytes, master NAK, START or STOP).
// Assumes: clk is many times faster than SCL; DATA_W is a multiple of 8;
// conv_done drops within a few clocks of conv_start and result is
// stable while conv_done is high.
module conv_result_i2c_port
    import conv_i2c_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = DEF_SLAVE_ADDR,
    parameter int         DATA_W      = 16,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              conv_start,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] result
);
    localparam int         NBYTES   = DATA_W / 8;
    localparam int         BW       = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [7:0] READ_REQ = {SLAVE_ADDR, 1'b1};

    // ---------------- line conditioning ----------------
    logic [1:0] raw_lines, clean_lines;
    logic       scl_f, sda_f;
    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN),
            .RST_VAL    (1'b1)
        ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_lines[g]),
            .dout (clean_lines[g])
        );
    end
    assign scl_f = clean_lines[1];
    assign sda_f = clean_lines[0];

    logic scl_rise, scl_fall, start_evt, stop_evt;

    bus_events u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (scl_f),
        .sda      (sda_f),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_evt(start_evt),
        .stop_evt (stop_evt)
    );

    // ---------------- protocol state ----------------
    port_state_t       st;
    logic [3:0]        bitcnt;
    logic [7:0]        addr_sr;
    logic [DATA_W-1:0] tx_sr;
    logic [BW-1:0]     byte_idx;
    logic              ack_addr;
    logic              master_nak;
    logic              reading;
    logic              sda_oe_q;
    logic              conv_start_q;
    logic              last_byte;

    assign last_byte = (byte_idx == BW'(NBYTES - 1));

    // Protocol sequencer: bus events first, then per-phase SCL edge handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= ST_IDLE;
            bitcnt       <= '0;
            addr_sr      <= '0;
            tx_sr        <= '0;
            byte_idx     <= '0;
            ack_addr     <= 1'b0;
            master_nak   <= 1'b0;
            reading      <= 1'b0;
            sda_oe_q     <= 1'b0;
            conv_start_q <= 1'b0;
        end else begin
            conv_start_q <= 1'b0;
            if (stop_evt) begin
                st       <= ST_IDLE;
                sda_oe_q <= 1'b0;
                reading  <= 1'b0;
                if (reading) conv_start_q <= 1'b1;
            end else if (start_evt) begin
                st       <= ST_ADDR;
                bitcnt   <= '0;
                sda_oe_q <= 1'b0;
                reading  <= 1'b0;
                if (reading) conv_start_q <= 1'b1;
            end else begin
                unique case (st)
                    ST_ADDR: begin
                        if (scl_rise && bitcnt < 4'd8) begin
                            addr_sr <= {addr_sr[6:0], sda_f};
                            bitcnt  <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            st <= ST_AACK;
                            if (addr_sr == READ_REQ && conv_done) begin
                                ack_addr <= 1'b1;
                                sda_oe_q <= 1'b1;
                                tx_sr    <= result;
                                reading  <= 1'b1;
                            end else begin
                                ack_addr <= 1'b0;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (scl_fall) begin
                            if (ack_addr) begin
                                st       <= ST_TX;
                                bitcnt   <= '0;
                                byte_idx <= '0;
                                sda_oe_q <= ~tx_sr[DATA_W-1];
                            end else begin
                                st       <= ST_SKIP;
                                sda_oe_q <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            tx_sr <= tx_sr << 1;
                            if (bitcnt == 4'd7) begin
                                st       <= ST_MACK;
                                sda_oe_q <= 1'b0;
                            end else begin
                                bitcnt   <= bitcnt + 1'b1;
                                sda_oe_q <= ~tx_sr[DATA_W-2];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            master_nak <= sda_f;
                        end else if (scl_fall) begin
                            if (master_nak || last_byte) begin
                                st           <= ST_SKIP;
                                reading      <= 1'b0;
                                conv_start_q <= 1'b1;
                            end else begin
                                st       <= ST_TX;
                                bitcnt   <= '0;
                                byte_idx <= byte_idx + 1'b1;
                                sda_oe_q <= ~tx_sr[DATA_W-1];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe     = sda_oe_q;
    assign conv_start = conv_start_q;
endmodule

// File: rtl/conv_port_checker.sv
// Module: conv_port_checker
// Temporal checks on the read port, bound into every instance.
// Assumes: connected to internal nets of conv_result_i2c_port by bind.
module conv_port_checker
    import conv_i2c_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        scl_f,
    input logic        sda_oe,
    input logic        conv_start,
    input logic        conv_done,
    input logic        start_evt,
    input logic        reading,
    input port_state_t st
);
    // R4: SDA enable moves only while filtered SCL is low
    a_r4_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f);

    // R5: conversion-start is a single-cycle pulse
    a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R2: an address ACK is only raised when the core was done
    a_r2_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_AACK && $rose(sda_oe)) |-> $past(conv_done));

    // R8: a START during a read ends it with a conversion-start pulse
    a_r8_start_ends_read: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt && reading) |=> conv_start);

    // R3: line released whenever the port is idle or ignoring the bus
    a_r3_released_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE || st == ST_SKIP) |-> !sda_oe);
endmodule

bind conv_result_i2c_port conv_port_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f     (scl_f),
    .sda_oe    (sda_oe),
    .conv_start(conv_start),
    .conv_done (conv_done),
    .start_evt (start_evt),
    .reading   (reading),
    .st        (st)
);

// File: tb/sim_conv_result_i2c_port.sv
// Bench: drives a bit-level I2C master against the read port and models
// the converter core (busy window after each conv_start).
module sim_conv_result_i2c_port;
    localparam int Q    = 8;    // quarter SCL bit, in system clocks
    localparam int BUSY = 600;  // model conversion time

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1, sda_m = 1'b1;
    logic        sda_oe, conv_start, conv_done;
    logic [15:0] result, next_result;
    int          busy_cnt, pulses;
    int          n_vec = 0, n_bad = 0;
    wire         sda_line = sda_m & ~sda_oe;

    conv_result_i2c_port u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .conv_start(conv_start),
        .conv_done(conv_done), .result(result)
    );

    // Converter core model
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_done <= 1'b1; busy_cnt <= 0; pulses <= 0; result <= 16'h8001;
        end else if (conv_start) begin
            pulses <= pulses + 1; conv_done <= 1'b0; busy_cnt <= BUSY;
        end else if (!conv_done) begin
            if (busy_cnt == 0) begin conv_done <= 1'b1; result <= next_result; end
            else busy_cnt <= busy_cnt - 1;
        end
    end

    task automatic wt(input int n); repeat (n) @(negedge clk); endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        if (!scl_m) begin sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); end
        sda_m = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(Q + 6);
    endtask

    // gl: 1 = short SCL spike in low phase, 2 = short SDA spike in high phase
    task automatic send_bit(input logic b, input int gl);
        sda_m = b; wt(Q / 2);
        if (gl == 1) begin scl_m = 1'b1; wt(2); scl_m = 1'b0; end
        wt(Q / 2); scl_m = 1'b1; wt(Q);
        if (gl == 2) begin sda_m = ~b; wt(2); sda_m = b; end
        wt(Q); scl_m = 1'b0; wt(Q);
    endtask

    task automatic read_bit(output logic b);
        sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); b = sda_line; wt(Q);
        scl_m = 1'b0; wt(Q);
    endtask

    task automatic read_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) read_bit(v[i]);
    endtask

    // Address byte plus ACK clock; dstab says conv_done was steady around the decision
    task automatic send_addr(input logic [7:0] a, input logic glitch,
                             output logic ackd, output logic dstab, output logic dval);
        logic d0, ab;
        for (int i = 7; i >= 1; i--)
            send_bit(a[i], glitch ? ((i == 6) ? 1 : (i == 5) ? 2 : 0) : 0);
        d0 = conv_done;
        send_bit(a[0], 0);
        dstab = (d0 == conv_done);
        dval  = d0;
        read_bit(ab);
        ackd = ~ab;
    endtask

    // After a refused address: every further clock must see a released line
    task automatic expect_released(input string req, input int nbits);
        logic [15:0] v = '0;
        for (int i = 0; i < nbits; i++) read_bit(v[i]);
        chk(req, v, (16'h1 << nbits) - 1);
    endtask

    function automatic logic exp_ack(input logic [7:0] a, input logic done);
        return (a == 8'h29) && done;
    endfunction

    initial begin : watchdog
        wt(190000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        logic ackd, st, dv;
        logic [7:0] b1, b2;
        int p0;
        logic [15:0] exp_d;
        void'($urandom(32'd2453));
        next_result = 16'hC3A5;
        wt(5);
        chk("R10 sda_oe in reset", sda_oe, 0);
        chk("R10 conv_start in reset", conv_start, 0);
        rst_n = 1'b1; wt(10);

        // Full read of the reset result
        p0 = pulses;
        bus_start(); send_addr(8'h29, 0, ackd, st, dv);
        chk("R1 ack when done", ackd, 1);
        read_byte(b1); send_bit(1'b0, 0); read_byte(b2); send_bit(1'b1, 0);
        bus_stop();
        chk("R4 data MSB first", {b1, b2}, 16'h8001);
        chk("R5 one pulse after full read", pulses - p0, 1);

        // Re-address while busy
        p0 = pulses;
        bus_start(); send_addr(8'h29, 0, ackd, st, dv);
        chk("R2 nak while busy", ackd, 0);
        expect_released("R2 released after nak", 9);
        bus_stop();
        chk("R2 no pulse on busy nak", pulses - p0, 0);
        wt(BUSY + 50);

        // Wrong address, then write request
        p0 = pulses;
        bus_start(); send_addr(8'h2B, 0, ackd, st, dv);
        chk("R3 nak wrong address", ackd, 0);
        expect_released("R3 ignored after wrong address", 12);
        bus_stop();
        bus_start(); send_addr(8'h28, 0, ackd, st, dv);
        chk("R3 nak write request", ackd, 0);
        expect_released("R3 ignored after write", 9);
        bus_stop();
        chk("R3 no pulse", pulses - p0, 0);

        // STOP straight after ACK discards result (MSB 1 so line is free)
        p0 = pulses;
        bus_start(); send_addr(8'h29, 0, ackd, st, dv);
        chk("R7 ack before discard", ackd, 1);
        bus_stop();
        chk("R7 discard pulses conv_start", pulses - p0, 1);
        wt(BUSY + 50);

        // Master NAK after the high byte
        p0 = pulses;
        bus_start(); send_addr(8'h29, 0, ackd, st, dv);
        read_byte(b1); send_bit(1'b1, 0);
        chk("R6 high byte", b1, 8'hC3);
        expect_released("R6 released after master nak", 8);
        bus_stop();
        chk("R6 one pulse", pulses - p0, 1);
        wt(BUSY + 50);

        // Repeated START in the middle of a read (low byte MSB is 1)
        p0 = pulses;
        bus_start(); send_addr(8'h29, 0, ackd, st, dv);
        read_byte(b1); send_bit(1'b0, 0);
        bus_start();
        wt(4);
        chk("R8 start mid read pulses", pulses - p0, 1);
        send_addr(8'h29, 0, ackd, st, dv);
        chk("R8 new address phase sees busy", ackd, 0);
        bus_stop();
        wt(BUSY + 50);
        bus_start(); send_addr(8'h2B, 0, ackd, st, dv);
        bus_start(); send_addr(8'h29, 0, ackd, st, dv);
        chk("R8 repeated start addresses", ackd, 1);
        read_byte(b1); send_bit(1'b0, 0); read_byte(b2); send_bit(1'b0, 0);
        bus_stop();
        chk("R5 low byte after master ack", {b1, b2}, 16'hC3A5);
        wt(BUSY + 50);

        // Spikes on both lines during the address
        p0 = pulses;
        bus_start(); send_addr(8'h29, 1, ackd, st, dv);
        chk("R9 spikes ignored", ackd, 1);
        bus_stop();
        chk("R9 one pulse", pulses - p0, 1);

        // Random phase
        for (int it = 0; it < 40; it++) begin
            logic [7:0] a;
            int mode;
            next_result = 16'($urandom);
            wt($urandom_range(BUSY + 200, 0));
            a = ($urandom_range(3, 0) != 0) ? 8'h29 : 8'($urandom);
            mode = $urandom_range(3, 0);
            p0 = pulses;
            bus_start(); send_addr(a, 0, ackd, st, dv);
            if (st) chk("R1 random ack", ackd, exp_ack(a, dv));
            if (ackd) begin
                exp_d = result;
                if (mode == 3 && exp_d[15]) begin
                    bus_stop();
                    chk("R7 random discard", pulses - p0, 1);
                end else if (mode == 2) begin
                    read_byte(b1); send_bit(1'b1, 0); bus_stop();
                    chk("R6 random high byte", b1, exp_d[15:8]);
                    chk("R6 random pulse", pulses - p0, 1);
                end else begin
                    read_byte(b1); send_bit(1'b0, 0); read_byte(b2);
                    send_bit(1'($urandom), 0); bus_stop();
                    chk("R4 random data", {b1, b2}, exp_d);
                    chk("R5 random pulse", pulses - p0, 1);
                end
            end else begin
                expect_released("R3 random nak released", 9);
                bus_stop();
                chk("R2 random no pulse", pulses - p0, 0);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule